// File: doc/BRIEF.md
# PS/2 Device Controller Control, Status and Interrupt Unit

This unit holds the software-visible state that surrounds a PS/2 device-side transmitter and receiver. A register port gives access to a control word (enable, two interrupt enables, transmit depth, acknowledge policy, a FIFO-clear strobe, and a line override with clock and data force values), the transmit data words, the last received byte, a status word and an interrupt-status word. The transmitter and receiver do the protocol sequencing. They report events to this unit as single-cycle pulses, and this unit keeps sticky flags for those events.

One interrupt line is formed from the receive and transmit flags, each gated by its own enable. Software can take direct control of the PS/2 clock and data drive values through the override. A typical use is to clock a stuck data line free after a frame error. Writes to the transmit words start a transfer only while the controller is enabled.

Register word addresses: 0 control, 1 to 4 transmit data, 5 received byte, 6 status, 7 interrupt status. Reads are combinational from `addr_i`. Writes take effect at the rising clock edge when `wr_en_i` is high.

Top module: `ps2_ctl_stat`

## Requirements
- R1: After reset the control word reads 0. The received byte, the interrupt status, the frame-error flag and the overwrite flag read 0. Transmit-empty (status bit 7) reads 1.
- R2: The control word is laid out as: enable bit 0, transmit interrupt enable bit 1, receive interrupt enable bit 2, depth bits 6:3, acknowledge policy bit 7, FIFO clear bit 8, override bit 9, clock force bit 10, data force bit 11. Bits 31:12 and bit 8 read 0. Enable, depth and acknowledge policy appear on `en_o`, `depth_o` and `ack_pol_o`.
- R3: Writing 1 to control bit 8 makes `fifo_clr_o` high for exactly the next cycle and sets transmit-empty.
- R4: When override is 1, `ps2_clk_o` equals the clock force bit and `ps2_dat_o` equals the data force bit. When override is 0, they follow `sm_clk_i` and `sm_dat_i`.
- R5: The frame-error flag is set by `frame_err_i` and read at status bit 2. The overwrite flag is set by `rx_ovf_i` and read at status bit 6. The receive flag is set by `rx_done_i` and read at interrupt-status bit 0. The transmit flag is set by `tx_done_i` and read at interrupt-status bit 1. Each flag is cleared by writing 1 to its bit and is unchanged by writing 0.
- R6: If a set event arrives in the same cycle as a write-1-to-clear of the same flag, the flag is 1 afterwards.
- R7: `irq_o` = (receive flag AND receive enable) OR (transmit flag AND transmit enable). The frame-error and overwrite flags do not drive it.
- R8: A write to a transmit data word always stores the value, which reads back at that address. When enable was 1 at the write, `tx_start_o` pulses for the next cycle and transmit-empty clears. When enable was 0, there is no pulse and transmit-empty is unchanged.
- R9: `tx_drained_i` sets transmit-empty. An enabled transmit write in the same cycle takes priority and leaves transmit-empty at 0.
- R10: On `rx_done_i`, `rx_byte_i` is captured and reads at address 5, bits 7:0. Writes to address 5 have no effect.
- R11: Status bits 0, 1, 3, 4, 5 and 11:8 show `clk_line_i`, `dat_line_i`, `rx_parity_i`, `rx_busy_i`, `tx_busy_i` and `byte_idx_i` directly. Writes do not change them, and a status write affects only bits 2 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` |
| frame_err_i | input | 1 | Frame error event pulse |
| rx_ovf_i | input | 1 | Receive overwrite event pulse |
| rx_done_i | input | 1 | Byte received event pulse |
| rx_byte_i | input | 8 | Received byte |
| rx_parity_i | input | 1 | Parity of last received byte |
| rx_busy_i | input | 1 | Receiver busy |
| tx_done_i | input | 1 | Stop bit sent event pulse |
| tx_drained_i | input | 1 | All bytes up to depth sent |
| tx_busy_i | input | 1 | Transmitter busy |
| byte_idx_i | input | 4 | Transmit byte index |
| clk_line_i | input | 1 | Synchronised clock line state |
| dat_line_i | input | 1 | Synchronised data line state |
| sm_clk_i | input | 1 | Clock drive from state machines |
| sm_dat_i | input | 1 | Data drive from state machines |
| ps2_clk_o | output | 1 | Clock line drive value |
| ps2_dat_o | output | 1 | Data line drive value |
| irq_o | output | 1 | Interrupt request |
| en_o | output | 1 | Controller enable |
| depth_o | output | 4 | Transmit depth minus one |
| ack_pol_o | output | 1 | Acknowledge policy |
| fifo_clr_o | output | 1 | FIFO clear pulse |
| tx_start_o | output | 1 | Transmit start pulse |
| tx_buf_o | output | 128 | Transmit data words, word 0 in the low bits |

## Verification
The case that needs care is an event pulse from the transmitter or receiver that lands in the same cycle as a software write-1-to-clear of the same flag. A similar case is a drained pulse that coincides with an enabled transmit write. The bench creates both cases with directed writes timed against the event pulses. It also creates them with a long randomised stretch in which writes and events collide often. A behavioural model applies the set-wins and write-wins rules, and its results are compared against every output and every read value on each clock.

// File: rtl/ps2_cs_pkg.sv
package ps2_cs_pkg;
  localparam int unsigned REG_AW   = 3;
  localparam int unsigned CTRL_W   = 12;
  localparam int unsigned TX_WORDS = 4;
  localparam int unsigned NFLAG    = 4;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL = 3'd0, A_TX0 = 3'd1, A_TX1 = 3'd2, A_TX2 = 3'd3,
    A_TX3 = 3'd4, A_RXD = 3'd5, A_STAT = 3'd6, A_INT = 3'd7
  } reg_addr_e;

  // control bit positions
  localparam int unsigned C_EN = 0, C_TXIE = 1, C_RXIE = 2, C_DEP = 3;
  localparam int unsigned C_ACK = 7, C_CLR = 8, C_OVR = 9, C_FCLK = 10, C_FDAT = 11;
  // status / interrupt-status W1C bit positions
  localparam int unsigned S_FE = 2, S_OV = 6, I_RX = 0, I_TX = 1;
  // flag vector indices
  localparam int unsigned F_FE = 0, F_OV = 1, F_RX = 2, F_TX = 3;
endpackage

// File: rtl/ps2_cs_regs.sv
module ps2_cs_regs
  import ps2_cs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NWORDS = TX_WORDS,
  parameter int unsigned RX_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [REG_AW-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     rx_done_i,
  input  logic [RX_W-1:0]          rx_byte_i,
  input  logic                     tx_drained_i,
  output logic [CTRL_W-1:0]        ctrl_o,
  output logic [NWORDS*DATA_W-1:0] tx_buf_o,
  output logic [RX_W-1:0]          rx_data_o,
  output logic                     tx_empty_o,
  output logic                     tx_start_o,
  output logic                     fifo_clr_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NWORDS-1:0] tx_hit;
  logic              tx_wr, ctrl_wr;

  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
  assign tx_wr   = |tx_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_wr) begin
      ctrl_q        <= wr_data_i[CTRL_W-1:0];
      ctrl_q[C_CLR] <= 1'b0;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_txw
    localparam logic [REG_AW-1:0] WA = REG_AW'(w + 1);
    assign tx_hit[w] = wr_en_i && (addr_i == WA);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tx_buf_o[w*DATA_W +: DATA_W] <= '0;
      else if (tx_hit[w]) tx_buf_o[w*DATA_W +: DATA_W] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_data_o <= '0;
    else if (rx_done_i) rx_data_o <= rx_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_empty_o <= 1'b1;
      tx_start_o <= 1'b0;
      fifo_clr_o <= 1'b0;
    end else begin
      tx_start_o <= tx_wr && ctrl_q[C_EN];
      fifo_clr_o <= ctrl_wr && wr_data_i[C_CLR];
      // enabled write has priority over drain/clear
      if (tx_wr && ctrl_q[C_EN]) tx_empty_o <= 1'b0;
      else if (tx_drained_i || (ctrl_wr && wr_data_i[C_CLR])) tx_empty_o <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;

  assert_start_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(ctrl_o[C_EN]));
  assert_clr_sets_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o |-> tx_empty_o);
  assert_clr_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[C_CLR]);
endmodule

// File: rtl/ps2_cs_flags.sv
module ps2_cs_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[k] <= 1'b0;
      else if (set_i[k]) flag_o[k] <= 1'b1;  // set wins
      else if (clr_i[k]) flag_o[k] <= 1'b0;
    end

    assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]);
    assert_w1c_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !flag_o[k]);
    assert_flag_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[k] && !set_i[k]) |=> $stable(flag_o[k]));
  end
endmodule

// File: rtl/ps2_cs_pinmux.sv
module ps2_cs_pinmux (
  input  logic ovr_i,
  input  logic frc_clk_i,
  input  logic frc_dat_i,
  input  logic sm_clk_i,
  input  logic sm_dat_i,
  output logic clk_o,
  output logic dat_o
);
  assign clk_o = ovr_i ? frc_clk_i : sm_clk_i;
  assign dat_o = ovr_i ? frc_dat_i : sm_dat_i;
endmodule

// File: rtl/ps2_ctl_stat.sv
module ps2_ctl_stat
  import ps2_cs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RX_W   = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [REG_AW-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [DATA_W-1:0]          rd_data_o,
  input  logic                       frame_err_i,
  input  logic                       rx_ovf_i,
  input  logic                       rx_done_i,
  input  logic [RX_W-1:0]            rx_byte_i,
  input  logic                       rx_parity_i,
  input  logic                       rx_busy_i,
  input  logic                       tx_done_i,
  input  logic                       tx_drained_i,
  input  logic                       tx_busy_i,
  input  logic [IDX_W-1:0]           byte_idx_i,
  input  logic                       clk_line_i,
  input  logic                       dat_line_i,
  input  logic                       sm_clk_i,
  input  logic                       sm_dat_i,
  output logic                       ps2_clk_o,
  output logic                       ps2_dat_o,
  output logic                       irq_o,
  output logic                       en_o,
  output logic [3:0]                 depth_o,
  output logic                       ack_pol_o,
  output logic                       fifo_clr_o,
  output logic                       tx_start_o,
  output logic [TX_WORDS*DATA_W-1:0] tx_buf_o
);
  localparam int unsigned STAT_W = 8 + IDX_W;

  logic [CTRL_W-1:0] ctrl;
  logic [RX_W-1:0]   rx_data;
  logic              tx_empty;
  logic [NFLAG-1:0]  f_set, f_clr, flags;
  logic              stat_wr, int_wr;
  logic [STAT_W-1:0] stat;

  ps2_cs_regs #(.DATA_W(DATA_W), .NWORDS(TX_WORDS), .RX_W(RX_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i,
    .rx_done_i, .rx_byte_i, .tx_drained_i,
    .ctrl_o(ctrl), .tx_buf_o, .rx_data_o(rx_data), .tx_empty_o(tx_empty),
    .tx_start_o, .fifo_clr_o
  );

  assign stat_wr = wr_en_i && (addr_i == A_STAT);
  assign int_wr  = wr_en_i && (addr_i == A_INT);

  always_comb begin
    f_set       = '0;
    f_clr       = '0;
    f_set[F_FE] = frame_err_i;
    f_set[F_OV] = rx_ovf_i;
    f_set[F_RX] = rx_done_i;
    f_set[F_TX] = tx_done_i;
    f_clr[F_FE] = stat_wr && wr_data_i[S_FE];
    f_clr[F_OV] = stat_wr && wr_data_i[S_OV];
    f_clr[F_RX] = int_wr && wr_data_i[I_RX];
    f_clr[F_TX] = int_wr && wr_data_i[I_TX];
  end

  ps2_cs_flags #(.N(NFLAG)) u_flags (
    .clk_i, .rst_ni, .set_i(f_set), .clr_i(f_clr), .flag_o(flags)
  );

  ps2_cs_pinmux u_pins (
    .ovr_i(ctrl[C_OVR]), .frc_clk_i(ctrl[C_FCLK]), .frc_dat_i(ctrl[C_FDAT]),
    .sm_clk_i, .sm_dat_i, .clk_o(ps2_clk_o), .dat_o(ps2_dat_o)
  );

  assign irq_o     = (flags[F_RX] & ctrl[C_RXIE]) | (flags[F_TX] & ctrl[C_TXIE]);
  assign en_o      = ctrl[C_EN];
  assign depth_o   = ctrl[C_DEP +: 4];
  assign ack_pol_o = ctrl[C_ACK];

  assign stat = {byte_idx_i, tx_empty, flags[F_OV], tx_busy_i, rx_busy_i,
                 rx_parity_i, flags[F_FE], dat_line_i, clk_line_i};

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rd_data_o = DATA_W'(ctrl);
      A_TX0:   rd_data_o = tx_buf_o[0*DATA_W +: DATA_W];
      A_TX1:   rd_data_o = tx_buf_o[1*DATA_W +: DATA_W];
      A_TX2:   rd_data_o = tx_buf_o[2*DATA_W +: DATA_W];
      A_TX3:   rd_data_o = tx_buf_o[3*DATA_W +: DATA_W];
      A_RXD:   rd_data_o = DATA_W'(rx_data);
      A_STAT:  rd_data_o = DATA_W'(stat);
      default: rd_data_o = DATA_W'({flags[F_TX], flags[F_RX]});
    endcase
  end

  assert_irq_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[C_RXIE] && !ctrl[C_TXIE]) |-> !irq_o);
  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags[F_RX] || flags[F_TX]));
  assert_override_pins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[C_OVR] |-> (ps2_clk_o == ctrl[C_FCLK] && ps2_dat_o == ctrl[C_FDAT]));
  assert_sm_pins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[C_OVR] |-> (ps2_clk_o == sm_clk_i && ps2_dat_o == sm_dat_i));
endmodule

// File: tb/sim_ps2_ctl_stat.sv
module sim_ps2_ctl_stat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rd_data;
  logic        frame_err, rx_ovf, rx_done, rx_parity, rx_busy;
  logic [7:0]  rx_byte;
  logic        tx_done, tx_drained, tx_busy;
  logic [3:0]  byte_idx;
  logic        clk_line, dat_line, sm_clk, sm_dat;
  logic        ps2_clk, ps2_dat, irq, en, ack_pol, fifo_clr, tx_start;
  logic [3:0]  depth;
  logic [127:0] tx_buf;

  int checks = 0, errors = 0;

  ps2_ctl_stat u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rd_data), .frame_err_i(frame_err), .rx_ovf_i(rx_ovf), .rx_done_i(rx_done),
    .rx_byte_i(rx_byte), .rx_parity_i(rx_parity), .rx_busy_i(rx_busy), .tx_done_i(tx_done),
    .tx_drained_i(tx_drained), .tx_busy_i(tx_busy), .byte_idx_i(byte_idx),
    .clk_line_i(clk_line), .dat_line_i(dat_line), .sm_clk_i(sm_clk), .sm_dat_i(sm_dat),
    .ps2_clk_o(ps2_clk), .ps2_dat_o(ps2_dat), .irq_o(irq), .en_o(en), .depth_o(depth),
    .ack_pol_o(ack_pol), .fifo_clr_o(fifo_clr), .tx_start_o(tx_start), .tx_buf_o(tx_buf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [11:0] m_ctrl;
  logic [31:0] m_tx [4];
  logic [7:0]  m_rx;
  logic        m_fe, m_ov, m_rxf, m_txf, m_empty, m_start, m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_rx = 0; m_fe = 0; m_ov = 0; m_rxf = 0; m_txf = 0;
      m_empty = 1; m_start = 0; m_clr = 0;
      foreach (m_tx[i]) m_tx[i] = 0;
    end else begin
      logic old_en, txw, clrw;
      old_en = m_ctrl[0];
      txw    = wr_en && addr >= 1 && addr <= 4;
      clrw   = wr_en && addr == 0 && wdata[8];
      m_start = txw && old_en;
      m_clr   = clrw;
      if (txw) m_tx[addr-1] = wdata;
      if (wr_en && addr == 0) begin m_ctrl = wdata[11:0]; m_ctrl[8] = 0; end
      if (txw && old_en) m_empty = 0;
      else if (tx_drained || clrw) m_empty = 1;
      if (wr_en && addr == 6 && wdata[2]) m_fe = 0;
      if (wr_en && addr == 6 && wdata[6]) m_ov = 0;
      if (wr_en && addr == 7 && wdata[0]) m_rxf = 0;
      if (wr_en && addr == 7 && wdata[1]) m_txf = 0;
      if (frame_err) m_fe = 1;
      if (rx_ovf) m_ov = 1;
      if (rx_done) begin m_rxf = 1; m_rx = rx_byte; end
      if (tx_done) m_txf = 1;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {20'b0, m_ctrl};
      3'd1, 3'd2, 3'd3, 3'd4: return m_tx[a-1];
      3'd5: return {24'b0, m_rx};
      3'd6: return {20'b0, byte_idx, m_empty, m_ov, tx_busy, rx_busy, rx_parity,
                    m_fe, dat_line, clk_line};
      default: return {30'b0, m_txf, m_rxf};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] e;
    string t;
    e = exp_rd(addr);
    case (addr)
      3'd0: t = "R2 ctrl read";
      3'd5: t = "R10 rx byte read";
      3'd6: t = "R5 R9 R11 status read";
      3'd7: t = "R5 R6 int status read";
      default: t = "R8 tx word read";
    endcase
    check(rd_data === e, t, rd_data, e);
    check(irq === ((m_rxf & m_ctrl[2]) | (m_txf & m_ctrl[1])), "R7 irq", 32'(irq),
          32'((m_rxf & m_ctrl[2]) | (m_txf & m_ctrl[1])));
    check(ps2_clk === (m_ctrl[9] ? m_ctrl[10] : sm_clk), "R4 clk pin", 32'(ps2_clk),
          32'(m_ctrl[9] ? m_ctrl[10] : sm_clk));
    check(ps2_dat === (m_ctrl[9] ? m_ctrl[11] : sm_dat), "R4 dat pin", 32'(ps2_dat),
          32'(m_ctrl[9] ? m_ctrl[11] : sm_dat));
    check({en, depth, ack_pol} === {m_ctrl[0], m_ctrl[6:3], m_ctrl[7]}, "R2 ctrl outs",
          32'({en, depth, ack_pol}), 32'({m_ctrl[0], m_ctrl[6:3], m_ctrl[7]}));
    check(tx_start === m_start, "R8 tx_start", 32'(tx_start), 32'(m_start));
    check(fifo_clr === m_clr, "R3 fifo_clr", 32'(fifo_clr), 32'(m_clr));
    check(tx_buf === {m_tx[3], m_tx[2], m_tx[1], m_tx[0]}, "R8 tx_buf",
          tx_buf[31:0], m_tx[0]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    wr_en = 0; frame_err = 0; rx_ovf = 0; rx_done = 0; tx_done = 0; tx_drained = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    quiet();
    addr = 0; wdata = 0; rx_byte = 8'h00; rx_parity = 0; rx_busy = 0; tx_busy = 0;
    byte_idx = 0; clk_line = 1; dat_line = 1; sm_clk = 1; sm_dat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk(3'd0, 32'h0, "R1 ctrl after reset");
    rd_chk(3'd5, 32'h0, "R1 rx after reset");
    rd_chk(3'd7, 32'h0, "R1 int after reset");
    rd_chk(3'd6, 32'h83, "R1 status after reset");
    tick();

    // R2 layout, clear bit reads zero
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 32'h0000_0EFF, "R2 ctrl readback");
    check(fifo_clr === 1'b1, "R3 clr pulse", 32'(fifo_clr), 32'h1);
    tick();
    check(fifo_clr === 1'b0, "R3 clr single", 32'(fifo_clr), 32'h0);

    // R4 override force values
    wr(3'd0, 32'h0000_0200);
    check({ps2_clk, ps2_dat} === 2'b00, "R4 forced low", 32'({ps2_clk, ps2_dat}), 32'h0);
    wr(3'd0, 32'h0000_0C00);
    check({ps2_clk, ps2_dat} === {sm_clk, sm_dat}, "R4 sm drives",
          32'({ps2_clk, ps2_dat}), 32'({sm_clk, sm_dat}));

    // R8 disabled write: stored, no start, empty unchanged
    wr(3'd1, 32'hA5A5_0001);
    check(tx_start === 1'b0, "R8 no start when disabled", 32'(tx_start), 32'h0);
    rd_chk(3'd6, 32'h83, "R8 empty kept when disabled");
    rd_chk(3'd1, 32'hA5A5_0001, "R8 stored when disabled");
    tick();
    // enabled write with drain in same cycle: write wins (R9)
    wr(3'd0, 32'h0000_0007);
    tx_drained = 1;
    wr(3'd2, 32'h1234_5678);
    tx_drained = 0;
    check(tx_start === 1'b1, "R8 start when enabled", 32'(tx_start), 32'h1);
    rd_chk(3'd6, 32'h03, "R9 write beats drain");
    tx_drained = 1; tick(); tx_drained = 0;
    rd_chk(3'd6, 32'h83, "R9 drain sets empty");
    tick();

    // R5 / R6 / R7 flags
    rx_done = 1; rx_byte = 8'h3C; tx_done = 1; frame_err = 1; rx_ovf = 1;
    tick(); quiet();
    rd_chk(3'd7, 32'h3, "R5 int flags set");
    check(irq === 1'b1, "R7 irq enabled", 32'(irq), 32'h1);
    rd_chk(3'd5, 32'h3C, "R10 rx captured");
    wr(3'd5, 32'hFF);
    rd_chk(3'd5, 32'h3C, "R10 rx write ignored");
    wr(3'd7, 32'h0);
    rd_chk(3'd7, 32'h3, "R5 write zero keeps");
    rx_done = 1; rx_byte = 8'h3C;
    wr(3'd7, 32'h3);
    quiet();
    rd_chk(3'd7, 32'h1, "R6 set wins rx, tx cleared");
    wr(3'd6, 32'hFFFF_FFFF);
    rd_chk(3'd6, 32'h83, "R11 status write only clears W1C");
    wr(3'd0, 32'h0000_0001);
    check(irq === 1'b0, "R7 irq masked", 32'(irq), 32'h0);

    // randomised collisions
    for (int n = 0; n < 3000; n++) begin
      wr_en = ($urandom_range(0, 2) == 0);
      addr = 3'($urandom);
      wdata = $urandom;
      frame_err = ($urandom_range(0, 5) == 0);
      rx_ovf = ($urandom_range(0, 5) == 0);
      rx_done = ($urandom_range(0, 4) == 0);
      tx_done = ($urandom_range(0, 4) == 0);
      tx_drained = ($urandom_range(0, 6) == 0);
      rx_byte = 8'($urandom);
      rx_parity = 1'($urandom); rx_busy = 1'($urandom); tx_busy = 1'($urandom);
      byte_idx = 4'($urandom); clk_line = 1'($urandom); dat_line = 1'($urandom);
      sm_clk = 1'($urandom); sm_dat = 1'($urandom);
      tick();
    end
    quiet();
    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule